// File: doc/BRIEF.md
# Cyclic High-Side Switch Controller

This block drives the enable of a battery-fed high-side switch that powers external loads such as wake-up switches. Software picks one of four behaviours through a 2-bit mode value. The output can be held off or held on. It can also be pulsed with one of two repeating on/off patterns, so a switch that stays closed only draws current during short windows. In the pulsed modes the block gives a one-cycle strobe late in each on-window, after the load has had time to settle. The wake-up input is read on that strobe, so it is sampled in step with the supply.

The switch reports overload through a flag. When that flag arrives while the output is driven, the block does four things. It shuts the output off and holds it off. It clears the diagnosis bit. It can raise an interrupt, which software may enable. If the system is asleep, it also forces a wake-up and records a dedicated reset-source code. A fresh mode write from software clears the shutdown, sets the diagnosis bit again and restarts the cycle.

Top module: `hss_cycle_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `out_en` is 0, `diag_ok` is 1, `irq` is 0, `wake_req` is 0, `wake_sample` is 0 and `rst_src` is 0. The mode is OFF.
- R2: Mode codes are 00 OFF and 01 ON. A write of 01 drives `out_en` high from the cycle after the write and keeps it high. A write of 00 keeps `out_en` low.
- R3: Mode 10 (cyclic A) repeats every PERIOD_A cycles. Counting from t=0, the cycle after the write, `out_en` is high when (t mod PERIOD_A) < ON_TICKS and low in all other cycles.
- R4: Mode 11 (cyclic B) behaves the same way with PERIOD_B in place of PERIOD_A.
- R5: `wake_sample` is a one-cycle pulse. It occurs only in the cyclic modes, at phase position SAMPLE_TICK of each on-window, and `out_en` is high in that cycle. It never occurs in OFF or ON.
- R6: If `ovl_flag` is high while `out_en` is high, then from the next cycle `out_en` is 0 and `diag_ok` is 0. Both stay that way until the next mode write. That write sets `diag_ok` to 1 and restarts the selected mode.
- R7: An accepted overload gives a one-cycle `irq` pulse in the next cycle, but only if `irq_en` was high. Otherwise `irq` stays 0.
- R8: An accepted overload while `sleep` is high gives a one-cycle `wake_req` pulse in the next cycle. In that same cycle `rst_src` becomes SRC_OVL (default 3'b101). `rst_src` holds that value until the next mode write, which clears it to 0.
- R9: `ovl_flag` while `out_en` is low is ignored. `diag_ok`, `irq`, `wake_req` and the output pattern are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value written on the strobe |
| ovl_flag | input | 1 | Overload indication from the switch |
| sleep | input | 1 | System is in its low-power sleep state |
| irq_en | input | 1 | Overload interrupt enable |
| out_en | output | 1 | Enable for the high-side switch |
| wake_sample | output | 1 | Strobe for reading the wake-up input |
| diag_ok | output | 1 | Diagnosis bit, cleared by overload |
| irq | output | 1 | Overload interrupt pulse |
| wake_req | output | 1 | Forced wake-up pulse |
| rst_src | output | 3 | Reset-source code |

## Verification
The assertions assume that `ovl_flag`, `sleep` and `irq_en` are synchronous to `clk` and stable around the edge. They also assume that `mode_wr` is a single-cycle strobe with valid data, and that an overload only matters while the output is driven. The bench changes every input on the falling edge and raises each of `mode_wr` and `ovl_flag` for exactly one cycle. It raises overloads both during on-windows and during off-windows, so the ignored case stays within the same timing rules.

// File: rtl/hss_pkg.sv
package hss_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_ON    = 2'b01,
        MODE_CYC_A = 2'b10,
        MODE_CYC_B = 2'b11
    } hss_mode_e;

    localparam int SRC_W = 3;

    typedef struct packed {
        logic             latched;
        logic             diag;
        logic             irq;
        logic             wake;
        logic [SRC_W-1:0] src;
    } hss_flt_s;
endpackage

// File: rtl/hss_phase_timer.sv
module hss_phase_timer
    import hss_pkg::*;
#(
    parameter int PERIOD_A    = 16,
    parameter int PERIOD_B    = 32,
    parameter int ON_TICKS    = 4,
    parameter int SAMPLE_TICK = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  hss_mode_e mode_i,
    output logic      on_phase_o,
    output logic      sample_o
);
    localparam int PMAX = (PERIOD_A > PERIOD_B) ? PERIOD_A : PERIOD_B;
    localparam int CW   = (PMAX > 2) ? $clog2(PMAX) : 1;
    localparam logic [CW-1:0] LAST_A = CW'(PERIOD_A - 1);
    localparam logic [CW-1:0] LAST_B = CW'(PERIOD_B - 1);
    localparam logic [CW-1:0] ON_C   = CW'(ON_TICKS);
    localparam logic [CW-1:0] SMP_C  = CW'(SAMPLE_TICK);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s          st_d, st_q;
    logic          cyclic;
    logic [CW-1:0] last;

    always_comb begin
        st_d   = st_q;
        cyclic = mode_i[1];
        last   = mode_i[0] ? LAST_B : LAST_A;
        if (restart || !cyclic) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        on_phase_o = cyclic && (st_q.cnt < ON_C);
        sample_o   = cyclic && (st_q.cnt == SMP_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The phase counter stays inside the period of the active cyclic mode.
    assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyclic && !restart) |-> (st_q.cnt <= last));

    // A sample strobe in a cyclic mode falls inside the on-window.
    assert_smp_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> on_phase_o);
endmodule

// File: rtl/hss_fault_ctrl.sv
module hss_fault_ctrl
    import hss_pkg::*;
#(
    parameter logic [SRC_W-1:0] SRC_OVL = 3'b101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovl_i,
    input  logic             out_on_i,
    input  logic             wr_i,
    input  logic             sleep_i,
    input  logic             irq_en_i,
    output logic             latched_o,
    output logic             diag_o,
    output logic             irq_o,
    output logic             wake_o,
    output logic [SRC_W-1:0] src_o
);
    hss_flt_s st_d, st_q;
    logic     ovl_ev;

    always_comb begin
        st_d   = st_q;
        ovl_ev = ovl_i && out_on_i;
        st_d.irq  = ovl_ev && irq_en_i;
        st_d.wake = ovl_ev && sleep_i;
        if (ovl_ev) begin
            st_d.latched = 1'b1;
            st_d.diag    = 1'b0;
            if (sleep_i) st_d.src = SRC_OVL;
        end else if (wr_i) begin
            st_d.latched = 1'b0;
            st_d.diag    = 1'b1;
            st_d.src     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{latched: 1'b0, diag: 1'b1, irq: 1'b0, wake: 1'b0, src: '0};
        else        st_q <= st_d;
    end

    assign latched_o = st_q.latched;
    assign diag_o    = st_q.diag;
    assign irq_o     = st_q.irq;
    assign wake_o    = st_q.wake;
    assign src_o     = st_q.src;

    // An interrupt pulse lasts one cycle.
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // A latched fault stays latched while no mode write arrives.
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !wr_i) |=> latched_o);
endmodule

// File: rtl/hss_cycle_ctrl.sv
module hss_cycle_ctrl
    import hss_pkg::*;
#(
    parameter int               PERIOD_A    = 16,
    parameter int               PERIOD_B    = 32,
    parameter int               ON_TICKS    = 4,
    parameter int               SAMPLE_TICK = 3,
    parameter logic [SRC_W-1:0] SRC_OVL     = 3'b101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             ovl_flag,
    input  logic             sleep,
    input  logic             irq_en,
    output logic             out_en,
    output logic             wake_sample,
    output logic             diag_ok,
    output logic             irq,
    output logic             wake_req,
    output logic [SRC_W-1:0] rst_src
);
    typedef struct packed {
        hss_mode_e mode;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic on_phase, smp_raw, latched;

    always_comb begin
        ctl_d = ctl_q;
        if (mode_wr) ctl_d.mode = hss_mode_e'(mode_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_OFF};
        else        ctl_q <= ctl_d;
    end

    hss_phase_timer #(
        .PERIOD_A   (PERIOD_A),
        .PERIOD_B   (PERIOD_B),
        .ON_TICKS   (ON_TICKS),
        .SAMPLE_TICK(SAMPLE_TICK)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (mode_wr),
        .mode_i    (ctl_q.mode),
        .on_phase_o(on_phase),
        .sample_o  (smp_raw)
    );

    hss_fault_ctrl #(
        .SRC_OVL(SRC_OVL)
    ) i_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovl_i    (ovl_flag),
        .out_on_i (out_en),
        .wr_i     (mode_wr),
        .sleep_i  (sleep),
        .irq_en_i (irq_en),
        .latched_o(latched),
        .diag_o   (diag_ok),
        .irq_o    (irq),
        .wake_o   (wake_req),
        .src_o    (rst_src)
    );

    always_comb begin
        out_en      = !latched && ((ctl_q.mode == MODE_ON) || on_phase);
        wake_sample = !latched && smp_raw;
    end

    // An accepted overload shuts the output and clears the diagnosis bit.
    assert_ovl_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_flag && out_en) |=> (!out_en && !diag_ok));

    // The wake-up strobe only fires while the output is driven.
    assert_smp_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_sample |-> out_en);

    // An interrupt only follows an enabled, accepted overload.
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ovl_flag && out_en && irq_en));

    // A forced wake-up comes with the overload reset-source code.
    assert_wake_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (rst_src == SRC_OVL));

    // An overload while the output is off leaves the diagnosis bit alone.
    assert_ovl_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_flag && !out_en && !mode_wr) |=> $stable(diag_ok));
endmodule

// File: tb/test_hss_cycle_ctrl.sv
module test_hss_cycle_ctrl;
    localparam int PA  = 16;
    localparam int PB  = 32;
    localparam int ONT = 4;
    localparam int SMP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       ovl_flag = 1'b0;
    logic       sleep = 1'b0;
    logic       irq_en = 1'b0;
    logic       out_en, wake_sample, diag_ok, irq, wake_req;
    logic [2:0] rst_src;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hss_cycle_ctrl #(
        .PERIOD_A(PA), .PERIOD_B(PB), .ON_TICKS(ONT), .SAMPLE_TICK(SMP), .SRC_OVL(3'b101)
    ) i_hss_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .ovl_flag(ovl_flag), .sleep(sleep), .irq_en(irq_en), .out_en(out_en),
        .wake_sample(wake_sample), .diag_ok(diag_ok), .irq(irq), .wake_req(wake_req),
        .rst_src(rst_src)
    );

    // {mode, cycles, expected on cycles, expected strobes}
    localparam logic [25:0] VEC [4] = '{
        {2'b00, 8'd64, 8'd0,  8'd0},
        {2'b01, 8'd64, 8'd64, 8'd0},
        {2'b10, 8'd64, 8'd16, 8'd4},
        {2'b11, 8'd64, 8'd8,  8'd2}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_ovl();
        ovl_flag = 1'b1;
        @(negedge clk);
        ovl_flag = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_en in reset", 8'(out_en), 8'd0);
        chk("R1 diag_ok in reset", 8'(diag_ok), 8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_en", 8'(out_en), 8'd0);
        chk("R1 irq", 8'(irq), 8'd0);
        chk("R1 wake_req", 8'(wake_req), 8'd0);
        chk("R1 wake_sample", 8'(wake_sample), 8'd0);
        chk("R1 rst_src", 8'(rst_src), 8'd0);

        for (int v = 0; v < 4; v++) begin
            logic [1:0] m;
            int ncyc, per, on_sum, smp_sum;
            string rq;
            m = VEC[v][25:24];
            ncyc = int'(VEC[v][23:16]);
            per = m[0] ? PB : PA;
            rq = (m == 2'b00 || m == 2'b01) ? "R2" : (m == 2'b10 ? "R3" : "R4");
            on_sum = 0;
            smp_sum = 0;
            write_mode(m);
            for (int t = 0; t < ncyc; t++) begin
                logic e_on, e_smp;
                e_on = (m == 2'b01) || (m[1] && ((t % per) < ONT));
                e_smp = m[1] && ((t % per) == SMP);
                chk({rq, " out_en per cycle"}, 8'(out_en), 8'(e_on));
                chk("R5 wake_sample per cycle", 8'(wake_sample), 8'(e_smp));
                on_sum += int'(out_en);
                smp_sum += int'(wake_sample);
                @(negedge clk);
            end
            chk({rq, " on-cycle total"}, 8'(on_sum), VEC[v][15:8]);
            chk("R5 strobe total", 8'(smp_sum), VEC[v][7:0]);
        end

        // R6/R7: overload in ON with interrupt enabled
        write_mode(2'b01);
        chk("R2 on after write", 8'(out_en), 8'd1);
        irq_en = 1'b1;
        sleep = 1'b0;
        pulse_ovl();
        chk("R6 out_en off", 8'(out_en), 8'd0);
        chk("R6 diag cleared", 8'(diag_ok), 8'd0);
        chk("R7 irq pulse", 8'(irq), 8'd1);
        chk("R8 no wake awake", 8'(wake_req), 8'd0);
        @(negedge clk);
        chk("R7 irq single", 8'(irq), 8'd0);
        repeat (5) @(negedge clk);
        chk("R6 stays off", 8'(out_en), 8'd0);
        write_mode(2'b01);
        chk("R6 rewrite restores out", 8'(out_en), 8'd1);
        chk("R6 rewrite sets diag", 8'(diag_ok), 8'd1);

        // R7: interrupt disabled
        irq_en = 1'b0;
        pulse_ovl();
        chk("R7 irq masked", 8'(irq), 8'd0);
        chk("R6 diag cleared masked", 8'(diag_ok), 8'd0);

        // R8: overload during sleep
        write_mode(2'b01);
        sleep = 1'b1;
        pulse_ovl();
        chk("R8 wake_req", 8'(wake_req), 8'd1);
        chk("R8 rst_src", 8'(rst_src), 8'h5);
        @(negedge clk);
        chk("R8 wake single", 8'(wake_req), 8'd0);
        chk("R8 rst_src held", 8'(rst_src), 8'h5);
        sleep = 1'b0;
        write_mode(2'b01);
        chk("R8 rst_src cleared", 8'(rst_src), 8'd0);

        // R9: overload during the off-window of cyclic A
        irq_en = 1'b1;
        write_mode(2'b10);
        repeat (ONT) @(negedge clk);
        chk("R9 off-window", 8'(out_en), 8'd0);
        pulse_ovl();
        chk("R9 diag unchanged", 8'(diag_ok), 8'd1);
        chk("R9 no irq", 8'(irq), 8'd0);
        repeat (PA - ONT - 1) @(negedge clk);
        chk("R9 pattern resumes", 8'(out_en), 8'd1);

        // R2: OFF keeps output low
        write_mode(2'b00);
        repeat (3) @(negedge clk);
        chk("R2 off", 8'(out_en), 8'd0);

        report();
    end
endmodule